// File: doc/BRIEF.md
# Reset-Cause and Interrupt Status Registers

This block holds two status registers of a system controller on a simple synchronous register bus. The first is a read-only word with one bit per interrupt source. Each bit shows the synchronized level of an active-low interrupt line, so a pending request reads as 0 and an idle source reads as 1. The second is a sticky record of why the system last restarted. Five single-cycle event pulses set its bits: external hard reset, watchdog expiry, reset button, software reset and power drop.

The reset-cause record is not cleared by the system reset. It starts at zero only when the device is configured, so software can read it after the restart has finished. Software then acknowledges each bit by writing 1 to it. Reads are registered, and the data belongs to the address presented one clock earlier.

Top module: `sysctl_status_regs`

## Requirements
- R1: A read at offset 0x80 returns the interrupt status word. Bit i equals the synchronized level of `irq_n[i]`: 0 means source i is pending, 1 means it is idle.
- R2: While and after the synchronous reset, and until the inputs have propagated, the interrupt status word reads 0xFFFF.
- R3: An `irq_n` change that is present at a rising edge is not on `bus_rdata` after two rising edges and is there after the third, with address 0x80 held.
- R4: A one-cycle pulse on an event input sets its cause bit at the next rising edge. The bits are: bit 0 = external hard reset, bit 1 = watchdog expiry, bit 2 = reset button, bit 3 = software reset, bit 4 = power drop.
- R5: The reset-cause bits hold their value through `rst_n` low. Events that arrive during reset are still captured.
- R6: Writing to offset 0x88 clears each cause bit whose write-data bit is 1. Cause bits whose write-data bit is 0 are unchanged.
- R7: When an event and a write-one clear hit the same cause bit in the same cycle, the bit ends up set.
- R8: Bits 15 to 5 of the reset-cause register read as 0, and writing 1 to them changes nothing.
- R9: Reads of any offset other than 0x80 and 0x88 return 0. Writes to 0x80 or to an unmapped offset change no register.
- R10: `bus_rdata` is registered. It shows the data for the address sampled at the previous rising edge and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low system reset (does not touch cause bits) |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_n | input | 16 | Active-low interrupt request lines, asynchronous |
| ev_ext_hard | input | 1 | Pulse: external hard reset seen |
| ev_wdog | input | 1 | Pulse: watchdog expired |
| ev_button | input | 1 | Pulse: reset button pressed |
| ev_soft | input | 1 | Pulse: software reset requested |
| ev_pwr_drop | input | 1 | Pulse: supply drop detected |

## Verification
A wrong cause bit shows at the next read of 0x88, one cycle after the address is presented. Because the register is sticky, the error stays visible until software clears it. A cleared or set bit that outlives a reset or a same-cycle clear therefore shows up in every later read until a write-one clears it. A synchronizer fault shows as a status word that changes one cycle early or late around the third edge after an input change, or as a value other than 0xFFFF right after reset.

// File: rtl/sysctl_status_pkg.sv
// Shared constants for the system-controller status registers.
// Assumes a byte-offset register map with 8-bit offsets.
package sysctl_status_pkg;
    localparam int unsigned REG_DATA_W = 16;
    localparam int unsigned CAUSE_W    = 5;
    localparam logic [7:0]  OFS_IRQ    = 8'h80;
    localparam logic [7:0]  OFS_CAUSE  = 8'h88;

    // Bit index of each restart cause inside the cause register.
    typedef enum int unsigned {
        CB_EXT_HARD = 0,
        CB_WDOG     = 1,
        CB_BUTTON   = 2,
        CB_SOFT     = 3,
        CB_PWR_DROP = 4
    } cause_bit_e;
endpackage

// File: rtl/irq_sync_bank.sv
// Two-flop synchronizer for each bit of an asynchronous active-low request bus.
// Assumes each input is a level that is held long enough to be sampled.
// On reset every stage loads RST_VAL, so all sources read idle.
module irq_sync_bank #(
    parameter int unsigned         WIDTH   = 16,
    parameter logic [WIDTH-1:0]    RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] stage_q;

        // Shift the raw level through two flops to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= {2{RST_VAL[i]}};
            end else begin
                stage_q <= {stage_q[0], async_in[i]};
            end
        end

        assign sync_out[i] = stage_q[1];
    end
endmodule

// File: rtl/cause_sticky_reg.sv
// Sticky cause bits: an event sets its bit, and a masked clear resets bits.
// Deliberately has no reset input. The bits start at zero only through the
// configuration-time initial value, so no system reset can wipe them.
// An event on the same cycle as a clear of the same bit wins.
module cause_sticky_reg #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] set_vec,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] bits
);
    logic [WIDTH-1:0] bits_q = '0;
    logic [WIDTH-1:0] clr_eff;
    logic [WIDTH-1:0] bits_d;

    // Gate the clear mask with the write decode.
    always_comb clr_eff = clr_en ? clr_mask : '0;

    // Clear first, then OR in events so that an event takes priority.
    always_comb bits_d = (bits_q & ~clr_eff) | set_vec;

    // Hold the record; this register is sensitive to no reset.
    always_ff @(posedge clk) begin
        bits_q <= bits_d;
    end

    assign bits = bits_q;
endmodule

// File: rtl/status_read_mux.sv
// Registered read decode for the status register pair.
// Assumes both inputs are already zero-extended to DATA_W.
// Unmapped offsets return zero. The data follows the address by one cycle.
module status_read_mux #(
    parameter int unsigned          ADDR_W    = 8,
    parameter int unsigned          DATA_W    = 16,
    parameter logic [ADDR_W-1:0]    IRQ_OFS   = 'h80,
    parameter logic [ADDR_W-1:0]    CAUSE_OFS = 'h88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] irq_word,
    input  logic [DATA_W-1:0] cause_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sel_data;

    // Select the word for the current offset.
    always_comb begin
        if (rd_addr == IRQ_OFS) begin
            sel_data = irq_word;
        end else if (rd_addr == CAUSE_OFS) begin
            sel_data = cause_word;
        end else begin
            sel_data = '0;
        end
    end

    // Register the selected word for the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= sel_data;
        end
    end
endmodule

// File: rtl/sysctl_status_regs.sv
// Top of the status register pair: the interrupt status word and the sticky
// reset-cause record. Assumes the event inputs are one-cycle pulses that are
// synchronous to clk, and the irq_n lines are asynchronous levels.
module sysctl_status_regs
    import sysctl_status_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = REG_DATA_W,
    parameter int unsigned       IRQ_W     = 16,
    parameter logic [ADDR_W-1:0] IRQ_OFS   = ADDR_W'(OFS_IRQ),
    parameter logic [ADDR_W-1:0] CAUSE_OFS = ADDR_W'(OFS_CAUSE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [IRQ_W-1:0]  irq_n,
    input  logic              ev_ext_hard,
    input  logic              ev_wdog,
    input  logic              ev_button,
    input  logic              ev_soft,
    input  logic              ev_pwr_drop
);
    localparam int unsigned CW = CAUSE_W;

    logic [IRQ_W-1:0]  irq_sync;
    logic [CW-1:0]     ev_vec;
    logic [CW-1:0]     cause_bits;
    logic              cause_wr;
    logic [DATA_W-1:0] irq_ext;
    logic [DATA_W-1:0] cause_ext;
    logic              unused_wdata;

    // Bring the request lines into the clock domain; idle after reset.
    irq_sync_bank #(
        .WIDTH   (IRQ_W),
        .RST_VAL ({IRQ_W{1'b1}})
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_n),
        .sync_out (irq_sync)
    );

    // Put each event pulse on its fixed cause bit.
    always_comb begin
        ev_vec              = '0;
        ev_vec[CB_EXT_HARD] = ev_ext_hard;
        ev_vec[CB_WDOG]     = ev_wdog;
        ev_vec[CB_BUTTON]   = ev_button;
        ev_vec[CB_SOFT]     = ev_soft;
        ev_vec[CB_PWR_DROP] = ev_pwr_drop;
    end

    // Decode a write to the cause register; other offsets are read-only or empty.
    always_comb cause_wr = bus_we && (bus_addr == CAUSE_OFS);

    cause_sticky_reg #(
        .WIDTH (CW)
    ) u_cause (
        .clk      (clk),
        .set_vec  (ev_vec),
        .clr_en   (cause_wr),
        .clr_mask (bus_wdata[CW-1:0]),
        .bits     (cause_bits)
    );

    // Zero-extend both words to the bus width; reserved bits read as zero.
    always_comb begin
        irq_ext   = DATA_W'(irq_sync);
        cause_ext = DATA_W'(cause_bits);
    end

    // Reserved write bits have no destination.
    assign unused_wdata = &{1'b0, bus_wdata[DATA_W-1:CW]};

    status_read_mux #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .IRQ_OFS   (IRQ_OFS),
        .CAUSE_OFS (CAUSE_OFS)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (bus_addr),
        .irq_word   (irq_ext),
        .cause_word (cause_ext),
        .rd_data    (bus_rdata)
    );
endmodule

// File: rtl/sysctl_status_chk.sv
// Assertion checker for sysctl_status_regs, attached by bind below.
// Observes the bus ports, the packed event vector and the cause bits.
module sysctl_status_chk #(
    parameter int unsigned       ADDR_W    = 8,
    parameter int unsigned       DATA_W    = 16,
    parameter int unsigned       CW        = 5,
    parameter logic [ADDR_W-1:0] IRQ_OFS   = 'h80,
    parameter logic [ADDR_W-1:0] CAUSE_OFS = 'h88
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CW-1:0]     ev_vec,
    input logic [CW-1:0]     cause_bits
);
    // R4 and R7: every pulsed bit is set on the next cycle, whatever the write did.
    p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_vec) |=> ((cause_bits & $past(ev_vec)) == $past(ev_vec)));

    // R5: with no event and no write, reset leaves the cause bits alone.
    p_hold_in_reset_r5: assert property (@(posedge clk)
        (!rst_n && !(|ev_vec) && !bus_we) |=> $stable(cause_bits));

    // R6: written ones are cleared when no event competes.
    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CAUSE_OFS && !(|ev_vec))
        |=> ((cause_bits & $past(bus_wdata[CW-1:0])) == '0));

    // R8: reserved cause bits read back as zero.
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == CAUSE_OFS) |=> (bus_rdata[DATA_W-1:CW] == '0));

    // R9: unmapped offsets read as zero.
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != IRQ_OFS && bus_addr != CAUSE_OFS) |=> (bus_rdata == '0));
endmodule

bind sysctl_status_regs sysctl_status_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CW        (sysctl_status_pkg::CAUSE_W),
    .IRQ_OFS   (IRQ_OFS),
    .CAUSE_OFS (CAUSE_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ev_vec     (ev_vec),
    .cause_bits (cause_bits)
);

// File: tb/sysctl_status_regs_bench.sv
// Scoreboard bench: driver tasks queue expected read data, and a monitor
// compares it with bus_rdata in the cycle the read completes.
module sysctl_status_regs_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [15:0] irq_n = 16'hFFFF;
    logic [4:0]  ev = 5'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    int          q_due[$];
    logic [15:0] q_exp[$];
    string       q_tag[$];

    logic [4:0]  m_cause = 5'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    sysctl_status_regs u_sysctl_status_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_n       (irq_n),
        .ev_ext_hard (ev[0]),
        .ev_wdog     (ev[1]),
        .ev_button   (ev[2]),
        .ev_soft     (ev[3]),
        .ev_pwr_drop (ev[4])
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Driver: present an address and queue the value due one cycle later (R10).
    task automatic rd(logic [7:0] a, logic [15:0] e, string tag);
        @(negedge clk);
        bus_addr = a;
        q_due.push_back(cyc + 1);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d, logic [4:0] pulse);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        ev        = pulse;
        @(negedge clk);
        bus_we = 1'b0;
        ev     = 5'b0;
        if (a == 8'h88) m_cause = m_cause & ~d[4:0];
        m_cause = m_cause | pulse;
    endtask

    task automatic pulse_ev(int b);
        @(negedge clk);
        ev[b] = 1'b1;
        @(negedge clk);
        ev = 5'b0;
        m_cause[b] = 1'b1;
    endtask

    // Monitor: pop each expected item in the cycle it falls due.
    initial begin
        forever begin
            @(negedge clk);
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                string       t;
                logic [15:0] e;
                t = q_tag.pop_front();
                e = q_exp.pop_front();
                void'(q_due.pop_front());
                check(t, bus_rdata, e);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog got=timeout exp=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 rdata zero in reset", bus_rdata, 16'h0000);
        rst_n = 1'b1;
        rd(8'h80, 16'hFFFF, "R2 irq word after reset");
        rd(8'h88, 16'h0000, "R4 cause zero at configuration");

        // R1: two distinct pending patterns.
        irq_n = 16'hA5F0;
        repeat (3) @(negedge clk);
        rd(8'h80, 16'hA5F0, "R1 pattern A5F0");
        irq_n = 16'h7FFE;
        repeat (3) @(negedge clk);
        rd(8'h80, 16'h7FFE, "R1 pattern 7FFE");

        // R3: synchronizer latency, with address 0x80 still held.
        irq_n = 16'h0F0F;
        @(negedge clk);
        @(negedge clk);
        check("R3 not visible after two edges", bus_rdata, 16'h7FFE);
        @(negedge clk);
        check("R3 visible after third edge", bus_rdata, 16'h0F0F);
        irq_n = 16'h7FFE;
        repeat (3) @(negedge clk);

        // R10: a new address does not change rdata before the next edge.
        @(negedge clk);
        bus_addr = 8'h84;
        #1;
        check("R10 rdata stable between edges", bus_rdata, 16'h7FFE);

        // R4: each event sets its own bit.
        for (int b = 0; b < 5; b++) begin
            pulse_ev(b);
            rd(8'h88, {11'b0, m_cause}, "R4 event sets bit");
        end

        // R5: reset leaves the record intact; an event during reset is kept.
        wr(8'h88, 16'h0010, 5'b0);
        rd(8'h88, 16'h000F, "R6 clear power-drop bit");
        @(negedge clk);
        rst_n = 1'b0;
        pulse_ev(4);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h88, 16'h001F, "R5 cause survives reset");
        repeat (2) @(negedge clk);
        rd(8'h80, 16'h7FFE, "R1 irq word after resync");

        // R6: write-one clears; write-zero keeps.
        wr(8'h88, 16'h0005, 5'b0);
        rd(8'h88, {11'b0, m_cause}, "R6 clear bits 0 and 2");
        wr(8'h88, 16'h0000, 5'b0);
        rd(8'h88, 16'h001A, "R6 write zero keeps bits");

        // R7: an event wins over a clear of the same bit.
        wr(8'h88, 16'h0002, 5'b00010);
        rd(8'h88, 16'h001A, "R7 watchdog event beats clear");
        wr(8'h88, 16'h0001, 5'b00001);
        rd(8'h88, 16'h001B, "R7 hard-reset event beats clear");

        // R8: reserved bits.
        wr(8'h88, 16'hFFE0, 5'b0);
        rd(8'h88, 16'h001B, "R8 reserved write no effect");

        // R9: read-only and unmapped offsets.
        wr(8'h80, 16'h0000, 5'b0);
        rd(8'h80, 16'h7FFE, "R9 write to status word ignored");
        wr(8'h84, 16'hFFFF, 5'b0);
        rd(8'h88, 16'h001B, "R9 unmapped write ignored");
        rd(8'h84, 16'h0000, "R9 unmapped read 84");
        rd(8'h00, 16'h0000, "R9 unmapped read 00");
        rd(8'hFF, 16'h0000, "R9 unmapped read FF");

        wr(8'h88, 16'h001F, 5'b0);
        rd(8'h88, 16'h0000, "R6 clear all");

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule